// File: doc/BRIEF.md
# Sticky Status Register Unit

This unit keeps the eight-bit status word of a flash write engine. The engine raises and lowers individual bits with one-cycle set and clear pulses, and the command decoder passes command bytes on so that a status-clear byte can wipe the accumulated error flags. Bit 7 tells the host whether the engine is idle (1) or busy (0). Bit 4 records a failed program operation, bit 3 an out-of-range programming supply, and bit 1 an attempt to alter a protected block. Bit 5 is a fourth cumulative error flag, and bits 2 and 6 are general engine flags. Bit 0 is reserved.

The host polls the word with the active-low output-enable and chip-enable strobes. The unit takes a copy of the word when the second of the two strobes is seen low. That copy stays on the read bus until the strobes are released and driven low again, so a poll never sees a word that changes partway through. The read bus is sixteen bits wide, and its upper byte is always zero.

Inputs are sampled on the rising clock edge. Reset is synchronous and active high.

Top module: `srstat_unit`

## Requirements
- R1: While reset is high, the status word and the held read copy both become 0x80, which means ready with no errors. The read bus then shows 0x0080.
- R2: A set pulse on bits 1 to 7 of `eng_set` makes the matching status bit 1 from the next cycle on. Bit 0 cannot be set and always reads 0.
- R3: A clear pulse on `eng_clr` takes effect only on bits 2, 6 and 7. Clear pulses on bits 1, 3, 4 and 5 leave those bits unchanged.
- R4: A command byte of 0x50, with `cmd_valid` high, clears bits 1, 3, 4 and 5 and leaves bits 2, 6 and 7 unchanged.
- R5: When `cmd_valid` is high and the command byte is any value other than 0x50, the status word does not change.
- R6: When a set pulse and a clear (either an engine clear or the 0x50 command) reach the same bit in the same cycle, the bit ends up 1.
- R7: The read copy is loaded from the status word in the first cycle in which `oe_n` and `ce_n` are both sampled low. Either strobe may be the later one.
- R8: While both strobes stay low, the read bus does not change, even if the status word does. A fresh copy is taken only after a strobe goes high and the pair is low again.
- R9: The upper byte of `rd_data` is always 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eng_set | input | 8 | Set pulses from the write engine, one per status bit |
| eng_clr | input | 8 | Clear pulses from the write engine, one per status bit |
| cmd_valid | input | 1 | High when `cmd_byte` holds a decoded command |
| cmd_byte | input | 8 | Command byte; 0x50 clears the error flags |
| oe_n | input | 1 | Output-enable read strobe, active low |
| ce_n | input | 1 | Chip-enable read strobe, active low |
| rd_data | output | 16 | Held copy of the status word, with the upper byte zero |

## Verification
Two functions can act on the same bit in the same cycle: a set pulse from the engine, and a clear that comes either from the engine or from the 0x50 command. The stimulus table has entries that drive both at once on an error bit, on the ready bit and on bit 6. After each entry a full read cycle shows whether the bit ended up 1. A separate entry drives a set on bit 1 together with the clear command. It checks that the other error flags are still cleared while bit 1 is set. Directed tests also change the word while a read is in progress, to check that the held copy stays put.

// File: rtl/srstat_pkg.sv
package srstat_pkg;
  localparam int unsigned SR_W_DEF    = 8;
  localparam int unsigned BUS_W_DEF   = 16;
  localparam logic [7:0]  RST_VAL_DEF = 8'h80;
  localparam logic [7:0]  SET_OK_DEF  = 8'hFE;  // engine may set bits 7..1
  localparam logic [7:0]  CLR_OK_DEF  = 8'hC4;  // engine may clear bits 7, 6, 2
  localparam logic [7:0]  STICKY_DEF  = 8'h3A;  // bits 5, 4, 3, 1
  localparam logic [7:0]  CLR_CMD_DEF = 8'h50;

  typedef enum logic [1:0] {
    BIT_HOLD  = 2'd0,
    BIT_SET   = 2'd1,
    BIT_CLEAR = 2'd2
  } bit_act_t;
endpackage

// File: rtl/srstat_cmd_dec.sv
module srstat_cmd_dec #(
  parameter int unsigned CMD_W   = 8,
  parameter logic [CMD_W-1:0] CLR_CODE = 8'h50
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_byte,
  output logic             clr_flags
);
  always_comb begin
    clr_flags = cmd_valid && (cmd_byte == CLR_CODE);
  end
endmodule

// File: rtl/srstat_core.sv
module srstat_core
  import srstat_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = 8'h80,
  parameter logic [W-1:0] SET_OK  = 8'hFE,
  parameter logic [W-1:0] CLR_OK  = 8'hC4,
  parameter logic [W-1:0] STICKY  = 8'h3A
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] eng_set,
  input  logic [W-1:0] eng_clr,
  input  logic         clr_flags,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    bit_act_t act;
    logic     cell_q;

    // Priority per bit: set, then engine clear, then clear command.
    always_comb begin
      if (eng_set[i] && SET_OK[i]) begin
        act = BIT_SET;
      end else if (eng_clr[i] && CLR_OK[i]) begin
        act = BIT_CLEAR;
      end else if (clr_flags && STICKY[i]) begin
        act = BIT_CLEAR;
      end else begin
        act = BIT_HOLD;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= RST_VAL[i];
      end else begin
        case (act)
          BIT_SET:   cell_q <= 1'b1;
          BIT_CLEAR: cell_q <= 1'b0;
          default:   cell_q <= cell_q;
        endcase
      end
    end

    assign status[i] = cell_q;
  end
endmodule

// File: rtl/srstat_snap.sv
module srstat_snap #(
  parameter int unsigned W     = 8,
  parameter int unsigned BUS_W = 16,
  parameter logic [W-1:0] RST_VAL = 8'h80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             ce_n,
  input  logic [W-1:0]     status,
  output logic [BUS_W-1:0] rd_data
);
  localparam int unsigned PAD = BUS_W - W;

  logic         rd_act;
  logic         rd_act_q;
  logic [W-1:0] snap_q;

  always_comb begin
    rd_act = !oe_n && !ce_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      snap_q   <= RST_VAL;
    end else begin
      rd_act_q <= rd_act;
      if (rd_act && !rd_act_q) begin
        snap_q <= status;
      end
    end
  end

  assign rd_data = {{PAD{1'b0}}, snap_q};
endmodule

// File: rtl/srstat_unit.sv
module srstat_unit
  import srstat_pkg::*;
#(
  parameter int unsigned W     = SR_W_DEF,
  parameter int unsigned BUS_W = BUS_W_DEF,
  parameter logic [W-1:0] RST_VAL  = RST_VAL_DEF,
  parameter logic [W-1:0] SET_OK   = SET_OK_DEF,
  parameter logic [W-1:0] CLR_OK   = CLR_OK_DEF,
  parameter logic [W-1:0] STICKY   = STICKY_DEF,
  parameter logic [W-1:0] CLR_CODE = CLR_CMD_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     eng_set,
  input  logic [W-1:0]     eng_clr,
  input  logic             cmd_valid,
  input  logic [W-1:0]     cmd_byte,
  input  logic             oe_n,
  input  logic             ce_n,
  output logic [BUS_W-1:0] rd_data
);
  logic         clr_flags;
  logic [W-1:0] status_q;

  srstat_cmd_dec #(.CMD_W(W), .CLR_CODE(CLR_CODE)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .clr_flags (clr_flags)
  );

  srstat_core #(
    .W(W), .RST_VAL(RST_VAL), .SET_OK(SET_OK), .CLR_OK(CLR_OK), .STICKY(STICKY)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .eng_set   (eng_set),
    .eng_clr   (eng_clr),
    .clr_flags (clr_flags),
    .status    (status_q)
  );

  srstat_snap #(.W(W), .BUS_W(BUS_W), .RST_VAL(RST_VAL)) u_snap (
    .clk     (clk),
    .rst     (rst),
    .oe_n    (oe_n),
    .ce_n    (ce_n),
    .status  (status_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/srstat_unit_chk.sv
module srstat_unit_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned BUS_W = 16,
  parameter logic [W-1:0] SET_OK   = 8'hFE,
  parameter logic [W-1:0] STICKY   = 8'h3A,
  parameter logic [W-1:0] CLR_CODE = 8'h50
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     eng_set,
  input logic             cmd_valid,
  input logic [W-1:0]     cmd_byte,
  input logic             oe_n,
  input logic             ce_n,
  input logic [W-1:0]     status_q,
  input logic [BUS_W-1:0] rd_data
);
  logic rd_act;
  logic clr_cmd;
  assign rd_act  = !oe_n && !ce_n;
  assign clr_cmd = cmd_valid && (cmd_byte == CLR_CODE);

  assert_bit0_zero_R2: assert property (@(posedge clk) disable iff (rst)
    status_q[0] == 1'b0);

  assert_set_lands_R6: assert property (@(posedge clk) disable iff (rst)
    ((eng_set & SET_OK) != '0) |=>
      ((status_q & $past(eng_set & SET_OK)) == $past(eng_set & SET_OK)));

  assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !clr_cmd |=>
      ((status_q & $past(status_q) & STICKY) == ($past(status_q) & STICKY)));

  assert_cmd_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_cmd && ((eng_set & STICKY) == '0)) |=> ((status_q & STICKY) == '0));

  assert_snap_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_act && $past(rd_act)) |=> $stable(rd_data));

  assert_upper_zero_R9: assert property (@(posedge clk) disable iff (rst)
    rd_data[BUS_W-1:W] == '0);
endmodule

bind srstat_unit srstat_unit_chk #(
  .W(W), .BUS_W(BUS_W), .SET_OK(SET_OK), .STICKY(STICKY), .CLR_CODE(CLR_CODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .eng_set   (eng_set),
  .cmd_valid (cmd_valid),
  .cmd_byte  (cmd_byte),
  .oe_n      (oe_n),
  .ce_n      (ce_n),
  .status_q  (status_q),
  .rd_data   (rd_data)
);

// File: tb/srstat_unit_bench.sv
`timescale 1ns/1ps
module srstat_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  eng_set = '0;
  logic [7:0]  eng_clr = '0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        oe_n = 1'b1;
  logic        ce_n = 1'b1;
  logic [15:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  srstat_unit u_srstat_unit (
    .clk(clk), .rst(rst), .eng_set(eng_set), .eng_clr(eng_clr),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .oe_n(oe_n), .ce_n(ce_n), .rd_data(rd_data)
  );

  // {cmd_valid, cmd_byte, set, clr, expected status after the step}
  localparam int NV = 14;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 8'h00, 8'h10, 8'h00, 8'h90},  // R2 program error
    {1'b0, 8'h00, 8'h00, 8'h80, 8'h10},  // R3 busy
    {1'b0, 8'h00, 8'h08, 8'h00, 8'h18},  // R2 voltage error
    {1'b0, 8'h00, 8'h00, 8'h18, 8'h18},  // R3 sticky clear ignored
    {1'b0, 8'h00, 8'h80, 8'h00, 8'h98},  // R2 ready
    {1'b1, 8'h70, 8'h00, 8'h00, 8'h98},  // R5 other command
    {1'b0, 8'h00, 8'h44, 8'h00, 8'hDC},  // R2 bits 6, 2
    {1'b0, 8'h00, 8'h00, 8'hFF, 8'h18},  // R3 only 7, 6, 2 clear
    {1'b1, 8'h50, 8'h00, 8'h00, 8'h00},  // R4 clear command
    {1'b0, 8'h00, 8'h01, 8'h00, 8'h00},  // R2 bit 0 reserved
    {1'b1, 8'h50, 8'h22, 8'h00, 8'h22},  // R6 set beats command
    {1'b0, 8'h00, 8'h80, 8'h80, 8'hA2},  // R6 set beats engine clear
    {1'b1, 8'h50, 8'h02, 8'h00, 8'h82},  // R6 R4 bit 1 set, bit 5 cleared
    {1'b0, 8'h00, 8'h40, 8'h40, 8'hC2}   // R6 bit 6
  };

  task automatic check(input logic [15:0] exp, input string req);
    n_cmp++;
    if (rd_data !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [7:0] cb,
                      input logic [7:0] s, input logic [7:0] c);
    @(negedge clk);
    cmd_valid = cv; cmd_byte = cb; eng_set = s; eng_clr = c;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_byte = '0; eng_set = '0; eng_clr = '0;
  endtask

  task automatic read_check(input logic [7:0] exp, input string req);
    @(negedge clk);
    oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk);
    check({8'h00, exp}, req);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(16'h0080, "R1");
    read_check(8'h80, "R1");

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8]);
      read_check(VEC[i][7:0], "R2-6 table");
    end

    // R1: reset returns the word to 0x80
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(16'h0080, "R1");
    read_check(8'h80, "R1");

    // R8: the copy holds while both strobes stay low
    @(negedge clk); oe_n = 1'b0; ce_n = 1'b0;
    @(negedge clk); eng_set = 8'h10;
    @(negedge clk); eng_set = '0;
    check(16'h0080, "R8");
    @(negedge clk);
    check(16'h0080, "R8");
    oe_n = 1'b1; ce_n = 1'b1;
    read_check(8'h90, "R8");

    // R7: oe_n falls first, ce_n falls later
    @(negedge clk); oe_n = 1'b0;
    @(negedge clk); eng_set = 8'h08;
    @(negedge clk); eng_set = '0; ce_n = 1'b0;
    @(negedge clk);
    check(16'h0098, "R7");
    oe_n = 1'b1; ce_n = 1'b1;

    // R7: ce_n falls first, oe_n falls later
    @(negedge clk); ce_n = 1'b0;
    @(negedge clk); eng_clr = 8'h80;
    @(negedge clk); eng_clr = '0; oe_n = 1'b0;
    @(negedge clk);
    check(16'h0018, "R7");
    oe_n = 1'b1; ce_n = 1'b1;

    // R9: upper byte stays zero with every bit set
    step(1'b0, 8'h00, 8'hFF, 8'h00);
    read_check(8'hFE, "R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: rd_data=%h expected=run completion", rd_data);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule